// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the software-visible face of a small LCD controller. It decodes a window of six 32-bit registers on a simple synchronous read/write bus: a control word, three timing words, a status word and a sub-panel word. It holds the configuration those registers carry. Panel dimensions are stored as the written field, which is the count minus one, and are presented to the rest of the controller as true counts. Reads return the stored fields together with bits that always read as one.

A separate frame sequencer drives pixel traffic. It sends single-cycle pulses when a frame completes, when the palette has been loaded, and when a synchronisation error occurs. These pulses set sticky status bits. A masked combination of the status bits drives one registered, level-sensitive interrupt line. A sync error is never masked.

Software starts and stops the panel by toggling the enable bit in the control word. Each toggle clears or sets status bits. It also produces a one-cycle notification to the sequencer.

Top module: `lcd_regbank`

## Requirements
- R1: The control word at offset 0x00 stores load mode from write bits 21:20, panel-type (TFT) flag from bit 7, a 2-bit interrupt mask from bits 4:3, mono flag from bit 1 and enable from bit 0, and keeps the other write bits selected by 0x01cff300. A read returns these fields in the same positions, with the TFT flag also copied to bit 23, all ORed with 0xfe000c34.
- R2: The word at 0x04 keeps bits 9:0 as line width minus one and bits 31:10 unchanged. `lcd_width` equals the stored field plus one. A read returns bits 31:10 and the stored field, with bits 3:0 forced to one.
- R3: The word at 0x08 keeps bits 9:0 as panel height minus one and bits 31:10 unchanged. `lcd_height` equals the stored field plus one. A read returns the stored value with no forced bits.
- R4: The word at 0x0c is stored whole. A read returns it with bits 31:26 forced to one.
- R5: The word at 0x14 keeps only the write bits selected by 0xa1ffffff.
- R6: The status word at 0x10 is read-only. Bit 6 is palette-done, bit 2 is sync-error and bit 0 is frame-done. Each bit is set by its sequencer pulse and stays set. Bus writes to 0x10 leave all three bits unchanged.
- R7: `irq` is registered one cycle after the status and mask it depends on. It is high when (frame-done and mask bit 0), or (palette-done and mask bit 1), or sync-error; otherwise it is low.
- R8: A control write that changes enable from 1 to 0 clears sync-error. The same write sets frame-done unless its load mode is 1. The cycle after the write, `lcd_en_change` is high for one cycle.
- R9: A control write that changes enable from 0 to 1 clears frame-done and palette-done. The cycle after the write, `lcd_en_change` is high for one cycle. When a toggle and a sequencer pulse arrive in the same cycle, the toggle's effect wins.
- R10: A read of an offset other than the six above returns zero. A write to such an offset changes no register.
- R11: Synchronous reset clears all stored fields and status bits. After reset the block reads: control 0xfe000c34, 0x04 as 0x0000000f, 0x0c as 0xfc000000, all others 0. `lcd_width` and `lcd_height` are 1, and `irq` is 0.
- R12: Read data is registered. It appears the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| seq_frame_done | input | 1 | Pulse: frame finished |
| seq_palette_done | input | 1 | Pulse: palette loaded |
| seq_sync_err | input | 1 | Pulse: synchronisation error |
| lcd_enable | output | 1 | Current enable bit |
| lcd_en_change | output | 1 | One-cycle notice of an enable toggle |
| lcd_load_mode | output | 2 | Stored load mode |
| lcd_width | output | DIM_W+1 | Pixels per line |
| lcd_height | output | DIM_W+1 | Lines per panel |
| irq | output | 1 | Level interrupt |

## Verification
The assertions take three things for granted. Reset is held for at least one clock edge. Sequencer pulses and bus strobes are sampled only at rising edges. Each toggle event is derived from the control write seen on that same edge. The assertions make no assumption about the order of events, so a pulse may coincide with a toggle. The bench changes every input on the falling edge and issues only one strobe at a time. It fires sequencer pulses between bus accesses, so that each status change can be traced to a single cause.

// File: rtl/lcd_regs_pkg.sv
`timescale 1ns/1ps
package lcd_regs_pkg;

  localparam int DATA_W = 32;

  // Byte offsets of the register window
  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_TIM0 = 8'h04;
  localparam logic [7:0] OFF_TIM1 = 8'h08;
  localparam logic [7:0] OFF_TIM2 = 8'h0c;
  localparam logic [7:0] OFF_STAT = 8'h10;
  localparam logic [7:0] OFF_SUBP = 8'h14;

  // Keep masks and forced-one patterns
  localparam logic [DATA_W-1:0] CTRL_KEEP_MASK = 32'h01cf_f300;
  localparam logic [DATA_W-1:0] CTRL_RD_ONES   = 32'hfe00_0c34;
  localparam logic [DATA_W-1:0] TIM0_RD_ONES   = 32'h0000_000f;
  localparam logic [DATA_W-1:0] TIM2_RD_ONES   = 32'hfc00_0000;
  localparam logic [DATA_W-1:0] SUBP_KEEP_MASK = 32'ha1ff_ffff;

  // Control field positions
  localparam int CB_EN      = 0;
  localparam int CB_MONO    = 1;
  localparam int CB_MASK_LO = 3;
  localparam int CB_TFT     = 7;
  localparam int CB_LM_LO   = 20;
  localparam int CB_TFT_DUP = 23;

  // Status field positions
  localparam int SB_FRAME = 0;
  localparam int SB_SYNC  = 2;
  localparam int SB_PAL   = 6;

  // Load mode that suppresses frame-done on disable
  localparam logic [1:0] LM_NO_FRAME = 2'd1;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CTRL,
    SEL_TIM0,
    SEL_TIM1,
    SEL_TIM2,
    SEL_STAT,
    SEL_SUBP
  } reg_sel_e;

endpackage

// File: rtl/lcd_addr_decode.sv
`timescale 1ns/1ps
module lcd_addr_decode
  import lcd_regs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
  localparam logic [ADDR_W-1:0] A_TIM0 = ADDR_W'(OFF_TIM0);
  localparam logic [ADDR_W-1:0] A_TIM1 = ADDR_W'(OFF_TIM1);
  localparam logic [ADDR_W-1:0] A_TIM2 = ADDR_W'(OFF_TIM2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [ADDR_W-1:0] A_SUBP = ADDR_W'(OFF_SUBP);

  // Full compare: misaligned or out-of-window offsets select nothing
  always_comb begin
    case (addr)
      A_CTRL:  sel = SEL_CTRL;
      A_TIM0:  sel = SEL_TIM0;
      A_TIM1:  sel = SEL_TIM1;
      A_TIM2:  sel = SEL_TIM2;
      A_STAT:  sel = SEL_STAT;
      A_SUBP:  sel = SEL_SUBP;
      default: sel = SEL_NONE;
    endcase
  end

endmodule

// File: rtl/lcd_cfg_store.sv
`timescale 1ns/1ps
module lcd_cfg_store
  import lcd_regs_pkg::*;
#(
  parameter int DIM_W = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  reg_sel_e                     sel,
  input  logic [DATA_W-1:0]            wdata,
  output logic                         enable,
  output logic [1:0]                   load_mode,
  output logic                         tft,
  output logic                         mono,
  output logic [1:0]                   irq_mask,
  output logic [DATA_W-1:0]            ctrl_extra,
  output logic [1:0][DIM_W-1:0]        dim_m1,
  output logic [1:0][DATA_W-DIM_W-1:0] tim_hi,
  output logic [DATA_W-1:0]            tim2,
  output logic [DATA_W-1:0]            subpanel,
  output logic                         en_rise,
  output logic                         en_fall,
  output logic [1:0]                   next_load_mode
);

  localparam int HI_W = DATA_W - DIM_W;

  logic ctrl_wr;
  assign ctrl_wr        = wr_en && (sel == SEL_CTRL);
  assign en_rise        = ctrl_wr &&  wdata[CB_EN] && !enable;
  assign en_fall        = ctrl_wr && !wdata[CB_EN] &&  enable;
  assign next_load_mode = wdata[CB_LM_LO +: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable     <= 1'b0;
      load_mode  <= 2'd0;
      tft        <= 1'b0;
      mono       <= 1'b0;
      irq_mask   <= 2'd0;
      ctrl_extra <= '0;
    end else if (ctrl_wr) begin
      enable     <= wdata[CB_EN];
      load_mode  <= wdata[CB_LM_LO +: 2];
      tft        <= wdata[CB_TFT];
      mono       <= wdata[CB_MONO];
      irq_mask   <= wdata[CB_MASK_LO +: 2];
      ctrl_extra <= wdata & CTRL_KEEP_MASK;
    end
  end

  // Two identical dimension words: count-minus-one plus upper timing bits
  for (genvar g = 0; g < 2; g++) begin : g_dim
    logic [DIM_W-1:0] d_q;
    logic [HI_W-1:0]  h_q;
    logic             hit;
    assign hit = wr_en && (sel == ((g == 0) ? SEL_TIM0 : SEL_TIM1));
    always_ff @(posedge clk) begin
      if (rst) begin
        d_q <= '0;
        h_q <= '0;
      end else if (hit) begin
        d_q <= wdata[DIM_W-1:0];
        h_q <= wdata[DATA_W-1:DIM_W];
      end
    end
    assign dim_m1[g] = d_q;
    assign tim_hi[g] = h_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tim2     <= '0;
      subpanel <= '0;
    end else if (wr_en) begin
      if (sel == SEL_TIM2) tim2     <= wdata;
      if (sel == SEL_SUBP) subpanel <= wdata & SUBP_KEEP_MASK;
    end
  end

  // A control write that repeats the enable value is not a toggle
  p_toggle_needs_change_r8: assert property (@(posedge clk) disable iff (rst)
    (en_rise || en_fall) |=> (enable != $past(enable)));

endmodule

// File: rtl/lcd_status_irq.sv
`timescale 1ns/1ps
module lcd_status_irq
  import lcd_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en_rise,
  input  logic       en_fall,
  input  logic [1:0] next_load_mode,
  input  logic       ev_frame,
  input  logic       ev_palette,
  input  logic       ev_sync,
  input  logic [1:0] irq_mask,
  output logic       frame_q,
  output logic       pal_q,
  output logic       sync_q,
  output logic       irq_q
);

  logic frame_n, pal_n, sync_n;

  // Sticky set from sequencer pulses; enable toggles take precedence
  always_comb begin
    frame_n = frame_q | ev_frame;
    pal_n   = pal_q   | ev_palette;
    sync_n  = sync_q  | ev_sync;
    if (en_fall) begin
      sync_n = 1'b0;
      if (next_load_mode != LM_NO_FRAME) frame_n = 1'b1;
    end
    if (en_rise) begin
      frame_n = 1'b0;
      pal_n   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= 1'b0;
      pal_q   <= 1'b0;
      sync_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      frame_q <= frame_n;
      pal_q   <= pal_n;
      sync_q  <= sync_n;
      irq_q   <= (frame_q & irq_mask[0]) | (pal_q & irq_mask[1]) | sync_q;
    end
  end

  p_sync_forces_irq_r7: assert property (@(posedge clk) disable iff (rst)
    sync_q |=> irq_q);

  p_fall_clears_sync_r8: assert property (@(posedge clk) disable iff (rst)
    en_fall |=> !sync_q);

  p_fall_sets_frame_r8: assert property (@(posedge clk) disable iff (rst)
    (en_fall && next_load_mode != LM_NO_FRAME) |=> frame_q);

  p_rise_clears_done_r9: assert property (@(posedge clk) disable iff (rst)
    en_rise |=> (!frame_q && !pal_q));

  p_frame_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (frame_q && !en_rise) |=> frame_q);

endmodule

// File: rtl/lcd_regbank.sv
`timescale 1ns/1ps
module lcd_regbank
  import lcd_regs_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              seq_frame_done,
  input  logic              seq_palette_done,
  input  logic              seq_sync_err,
  output logic              lcd_enable,
  output logic              lcd_en_change,
  output logic [1:0]        lcd_load_mode,
  output logic [DIM_W:0]    lcd_width,
  output logic [DIM_W:0]    lcd_height,
  output logic              irq
);

  localparam int HI_W = DATA_W - DIM_W;

  reg_sel_e                 sel;
  logic                     enable, tft, mono;
  logic [1:0]               load_mode, irq_mask, next_lm;
  logic [DATA_W-1:0]        ctrl_extra, tim2, subpanel;
  logic [1:0][DIM_W-1:0]    dim_m1;
  logic [1:0][HI_W-1:0]     tim_hi;
  logic                     en_rise, en_fall;
  logic                     frame_q, pal_q, sync_q, irq_q;
  logic [DATA_W-1:0]        rd_val;

  lcd_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  lcd_cfg_store #(.DIM_W(DIM_W)) u_cfg (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (bus_wr),
    .sel            (sel),
    .wdata          (bus_wdata),
    .enable         (enable),
    .load_mode      (load_mode),
    .tft            (tft),
    .mono           (mono),
    .irq_mask       (irq_mask),
    .ctrl_extra     (ctrl_extra),
    .dim_m1         (dim_m1),
    .tim_hi         (tim_hi),
    .tim2           (tim2),
    .subpanel       (subpanel),
    .en_rise        (en_rise),
    .en_fall        (en_fall),
    .next_load_mode (next_lm)
  );

  lcd_status_irq u_stat (
    .clk            (clk),
    .rst            (rst),
    .en_rise        (en_rise),
    .en_fall        (en_fall),
    .next_load_mode (next_lm),
    .ev_frame       (seq_frame_done),
    .ev_palette     (seq_palette_done),
    .ev_sync        (seq_sync_err),
    .irq_mask       (irq_mask),
    .frame_q        (frame_q),
    .pal_q          (pal_q),
    .sync_q         (sync_q),
    .irq_q          (irq_q)
  );

  // Readback assembly with forced-one bits
  always_comb begin
    case (sel)
      SEL_CTRL: rd_val = ctrl_extra | CTRL_RD_ONES
                       | (DATA_W'(tft)       << CB_TFT_DUP)
                       | (DATA_W'(load_mode) << CB_LM_LO)
                       | (DATA_W'(tft)       << CB_TFT)
                       | (DATA_W'(irq_mask)  << CB_MASK_LO)
                       | (DATA_W'(mono)      << CB_MONO)
                       | (DATA_W'(enable)    << CB_EN);
      SEL_TIM0: rd_val = {tim_hi[0], dim_m1[0]} | TIM0_RD_ONES;
      SEL_TIM1: rd_val = {tim_hi[1], dim_m1[1]};
      SEL_TIM2: rd_val = tim2 | TIM2_RD_ONES;
      SEL_STAT: rd_val = (DATA_W'(pal_q)   << SB_PAL)
                       | (DATA_W'(sync_q)  << SB_SYNC)
                       | (DATA_W'(frame_q) << SB_FRAME);
      SEL_SUBP: rd_val = subpanel;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata     <= '0;
      lcd_en_change <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_val;
      lcd_en_change <= en_rise | en_fall;
    end
  end

  assign lcd_enable    = enable;
  assign lcd_load_mode = load_mode;
  assign lcd_width     = (DIM_W+1)'(dim_m1[0]) + (DIM_W+1)'(1);
  assign lcd_height    = (DIM_W+1)'(dim_m1[1]) + (DIM_W+1)'(1);
  assign irq           = irq_q;

  p_unmapped_reads_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_NONE) |=> (bus_rdata == '0));

  p_rdata_holds_r12: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  p_en_change_marks_toggle_r9: assert property (@(posedge clk) disable iff (rst)
    lcd_en_change |-> (lcd_enable != $past(lcd_enable)));

endmodule

// File: tb/lcd_regbank_tb_top.sv
`timescale 1ns/1ps
module lcd_regbank_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        seq_frame_done = 1'b0, seq_palette_done = 1'b0, seq_sync_err = 1'b0;
  logic        lcd_enable, lcd_en_change, irq;
  logic [1:0]  lcd_load_mode;
  logic [10:0] lcd_width, lcd_height;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  lcd_regbank dut_i (
    .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .seq_frame_done, .seq_palette_done, .seq_sync_err,
    .lcd_enable, .lcd_en_change, .lcd_load_mode, .lcd_width, .lcd_height, .irq
  );

  // addr, write data, expected readback after the write
  localparam logic [71:0] VEC [0:7] = '{
    {8'h04, 32'hffff_fc05, 32'hffff_fc0f},
    {8'h08, 32'h0000_0a3f, 32'h0000_0a3f},
    {8'h0c, 32'h0123_4567, 32'hfd23_4567},
    {8'h14, 32'hffff_ffff, 32'ha1ff_ffff},
    {8'h10, 32'hffff_ffff, 32'h0000_0000},
    {8'h20, 32'hffff_ffff, 32'h0000_0000},
    {8'h00, 32'hffff_fffe, 32'hffff_ffbe},
    {8'h00, 32'h0000_0000, 32'hfe00_0c34}
  };

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h00: return "R1";
      8'h04: return "R2";
      8'h08: return "R3";
      8'h0c: return "R4";
      8'h10: return "R6";
      8'h14: return "R5";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: seq_frame_done = 1'b1;
      1: seq_palette_done = 1'b1;
      default: seq_sync_err = 1'b1;
    endcase
    @(negedge clk);
    seq_frame_done = 1'b0; seq_palette_done = 1'b0; seq_sync_err = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R12 watchdog: actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    // R11: state during and right after reset
    check("R11 rdata", bus_rdata, 32'h0);
    check("R11 irq", 32'(irq), 32'h0);
    rst = 1'b0;
    idle(1);
    check("R11 enable", 32'(lcd_enable), 32'h0);
    check("R11 width", 32'(lcd_width), 32'd1);
    rd(8'h00, v); check("R11 ctrl", v, 32'hfe00_0c34);
    rd(8'h04, v); check("R11 tim0", v, 32'h0000_000f);

    // Table walk: write then read back
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      check(tag_of(VEC[i][71:64]), v, VEC[i][31:0]);
    end

    check("R2 width", 32'(lcd_width), 32'd6);
    check("R3 height", 32'(lcd_height), 32'h240);

    // R9 enable rise
    wr(8'h00, 32'h0000_0001);
    check("R9 en_change", 32'(lcd_en_change), 32'h1);
    check("R9 enable", 32'(lcd_enable), 32'h1);
    idle(1);
    check("R9 en_change one cycle", 32'(lcd_en_change), 32'h0);

    // R6 frame-done sticky; R7 masked off
    pulse(0);
    rd(8'h10, v); check("R6 frame", v, 32'h1);
    check("R7 masked frame", 32'(irq), 32'h0);
    wr(8'h00, 32'h0000_0009);
    check("R8 no toggle", 32'(lcd_en_change), 32'h0);
    idle(1);
    check("R7 frame irq", 32'(irq), 32'h1);
    wr(8'h00, 32'h0000_0011);
    idle(1);
    check("R7 mask swap", 32'(irq), 32'h0);
    pulse(1);
    idle(1);
    check("R7 palette irq", 32'(irq), 32'h1);
    rd(8'h10, v); check("R6 pal+frame", v, 32'h41);
    wr(8'h10, 32'h0000_0000);
    rd(8'h10, v); check("R6 write ignored", v, 32'h41);

    // R7 sync error unmasked
    wr(8'h00, 32'h0000_0001);
    idle(1);
    check("R7 mask zero", 32'(irq), 32'h0);
    pulse(2);
    idle(1);
    check("R7 sync irq", 32'(irq), 32'h1);
    rd(8'h10, v); check("R6 sync", v, 32'h45);

    // R8 disable in load mode 0
    wr(8'h00, 32'h0000_0000);
    check("R8 en_change", 32'(lcd_en_change), 32'h1);
    rd(8'h10, v); check("R8 disable status", v, 32'h41);
    check("R8 irq low", 32'(irq), 32'h0);

    // R9 re-enable clears done bits
    wr(8'h00, 32'h0000_0001);
    rd(8'h10, v); check("R9 cleared", v, 32'h0);

    // R8 disable in load mode 1: no frame-done, sync cleared
    pulse(2);
    wr(8'h00, 32'h0010_0000);
    rd(8'h10, v); check("R8 lm1 disable", v, 32'h0);
    check("R8 load mode", 32'(lcd_load_mode), 32'h1);

    // R10 unmapped
    wr(8'h18, 32'hffff_ffff);
    rd(8'h18, v); check("R10 read", v, 32'h0);
    rd(8'h01, v); check("R10 misaligned", v, 32'h0);
    rd(8'h14, v); check("R10 subp kept", v, 32'ha1ff_ffff);
    rd(8'h04, v); check("R10 tim0 kept", v, 32'hffff_fc0f);

    // R12 hold between reads
    idle(3);
    check("R12 hold", bus_rdata, 32'hffff_fc0f);

    // R11 reset mid-run
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
    check("R11 width", 32'(lcd_width), 32'd1);
    check("R11 height", 32'(lcd_height), 32'd1);
    rd(8'h00, v); check("R11 ctrl", v, 32'hfe00_0c34);
    rd(8'h0c, v); check("R11 tim2", v, 32'hfc00_0000);
    rd(8'h14, v); check("R11 subp", v, 32'h0);
    rd(8'h10, v); check("R11 status", v, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule